// File: doc/BRIEF.md
# Cassette FSK Tone Generator

This block generates the square-wave signal written to tape. Two sources are available. In data mode a serial data bit picks one of two audio tones: about 2 kHz while the bit is 1 and about 1.5 kHz while it is 0. In sync mode the block sends a tempo clock to the tape instead, so that a recorded track can drive a sequencer later. A level input selects the mode. The output level always changes on a clock edge, and with a steady data bit the high and low halves of each tone period are equal.

The tone half-periods are counts of system-clock cycles, worked out from the clock frequency and the two tone frequencies given as parameters. The block changes tone only at a half-period boundary and changes mode only while the output is low, so no switch can cut a pulse short. A second, independent path watches an activity signal from the tape receiver. It raises a carrier-present flag while that signal keeps toggling and holds the flag low when the signal goes quiet.

Top module: `fsk_tape_tone`

## Requirements
- R1: In data mode with the data bit at 1, each half of the output wave lasts HALF_HI = round(CLK_HZ / (2 * TONE_HI_HZ)) clock cycles (250 with the defaults), so high and low halves are equal (50% duty).
- R2: In data mode with the data bit at 0, each half of the output wave lasts HALF_LO = round(CLK_HZ / (2 * TONE_LO_HZ)) clock cycles (333 with the defaults), again with equal halves.
- R3: The data bit is sampled only on the clock edge where the output toggles. That sample sets the length of the half that starts there, and a change of the bit in the middle of a half does not change that half's length.
- R4: In sync mode (sync_mode_i = 1) the output copies sync_clk_i with a latency of exactly three clock cycles: two synchronizer stages and the output register.
- R5: A change of sync_mode_i takes effect only on a clock edge where the output is low. A request made while the output is high waits, and the current high half runs to its full length.
- R6: On the switch into data mode the output is low and stays low for one full half-period of the newly sampled tone. The first rising edge appears half-period + 1 cycles after the select changes.
- R7: carrier_det_o goes high three cycles after carrier_i toggles. It stays high while toggles keep arriving less than CD_HOLD_CYCLES apart, drops low CD_HOLD_CYCLES + 3 cycles after the last toggle, and stays low while carrier_i is constant.
- R8: During and right after reset, tape_o and carrier_det_o are low and the block is in data mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (CLK_HZ) |
| rst | input | 1 | Synchronous reset, active high |
| sync_mode_i | input | 1 | Mode select: 1 = pass the sync clock, 0 = FSK data tones |
| data_bit_i | input | 1 | Serial data bit that picks the tone (1 = high tone) |
| sync_clk_i | input | 1 | Asynchronous tempo clock to record in sync mode |
| carrier_i | input | 1 | Asynchronous activity signal from the tape receiver |
| tape_o | output | 1 | Square-wave tape signal |
| carrier_det_o | output | 1 | High while receiver activity is present |

## Verification
Some properties are checked on every cycle. A mode change happens only on a low output, and entry into data mode leaves the output low. In steady sync mode the output equals the synchronized sync clock one cycle later. In data mode every half length, timed from a toggle, is one of the two tone constants. The carrier flag is low whenever the receiver signal has been quiet for the hold window, and reset leaves both outputs idle. Other behaviour can be shown only by the bench's scenarios: which of the two lengths a half should have for the data bit sampled at its start, the exact cycle of the first edge after a mode select, the completion of a deferred mode request, and the three-cycle rise of the carrier flag.

// File: rtl/fsk_tone_pkg.sv
package fsk_tone_pkg;

    typedef enum logic {
        MODE_DATA = 1'b0,
        MODE_SYNC = 1'b1
    } tape_mode_e;

    // Asynchronous inputs, carried through the synchronizer as one vector
    typedef struct packed {
        logic sync_clk;
        logic carrier;
    } ext_bits_t;

    // Registered state of the output stage
    typedef struct packed {
        tape_mode_e mode;
        logic       level;
    } tape_state_t;

    // Clock cycles in one half of a tone period, rounded to the nearest integer
    function automatic int unsigned half_cycles(input int unsigned clk_hz,
                                                input int unsigned tone_hz);
        return (clk_hz + tone_hz) / (2 * tone_hz);
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fsk_bit_sync.sv
module fsk_bit_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES <= 1) begin : g_single
            logic [WIDTH-1:0] stage_q;
            always_ff @(posedge clk) begin
                if (rst) stage_q <= '0;
                else     stage_q <= d;
            end
            assign q = stage_q;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d};
            end
            assign q = chain_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/fsk_half_timer.sv
module fsk_half_timer #(
    parameter int unsigned HALF_HI = 250,
    parameter int unsigned HALF_LO = 333
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_i,
    input  logic data_bit_i,
    output logic flip_o
);

    localparam int unsigned LONGEST = fsk_tone_pkg::max_u(HALF_HI, HALF_LO);
    localparam int unsigned CW      = $clog2(LONGEST + 1);

    logic [CW-1:0] cnt_q;
    logic          hi_sel_q;   // tone chosen for the running half
    logic [CW-1:0] last_cnt;

    assign last_cnt = hi_sel_q ? CW'(HALF_HI - 1) : CW'(HALF_LO - 1);
    assign flip_o   = (cnt_q == last_cnt);

    // The data bit is taken only when a new half starts
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            hi_sel_q <= 1'b0;
        end else if (restart_i || flip_o) begin
            cnt_q    <= '0;
            hi_sel_q <= data_bit_i;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/fsk_carrier_watch.sv
module fsk_carrier_watch #(
    parameter int unsigned HOLD = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic sense_i,
    output logic present_o
);

    localparam int unsigned CW = $clog2(HOLD + 1);

    logic          sense_prev_q;
    logic          toggled;
    logic [CW-1:0] hold_q;

    assign toggled   = sense_i ^ sense_prev_q;
    assign present_o = (hold_q != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_prev_q <= 1'b0;
            hold_q       <= '0;
        end else begin
            sense_prev_q <= sense_i;
            if (toggled)
                hold_q <= CW'(HOLD);
            else if (hold_q != '0)
                hold_q <= hold_q - 1'b1;
        end
    end

endmodule

// File: rtl/fsk_tape_tone.sv
module fsk_tape_tone
    import fsk_tone_pkg::*;
#(
    parameter int unsigned CLK_HZ         = 1_000_000,
    parameter int unsigned TONE_HI_HZ     = 2000,
    parameter int unsigned TONE_LO_HZ     = 1500,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned CD_HOLD_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_mode_i,
    input  logic data_bit_i,
    input  logic sync_clk_i,
    input  logic carrier_i,
    output logic tape_o,
    output logic carrier_det_o
);

    localparam int unsigned HALF_HI = half_cycles(CLK_HZ, TONE_HI_HZ);
    localparam int unsigned HALF_LO = half_cycles(CLK_HZ, TONE_LO_HZ);
    localparam int unsigned EXT_W   = $bits(ext_bits_t);

    ext_bits_t   raw_in;
    ext_bits_t   synced;
    logic [EXT_W-1:0] synced_v;
    logic        sync_s;
    logic        sense_s;

    tape_state_t st_q, st_d;
    tape_mode_e  mode_req;
    logic        switch_ok;
    logic        enter_data;
    logic        flip;

    assign raw_in = '{sync_clk: sync_clk_i, carrier: carrier_i};

    fsk_bit_sync #(
        .WIDTH  (EXT_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (synced_v)
    );

    assign synced  = ext_bits_t'(synced_v);
    assign sync_s  = synced.sync_clk;
    assign sense_s = synced.carrier;

    // Mode arbitration: a pending request is taken only on a low output
    assign mode_req   = sync_mode_i ? MODE_SYNC : MODE_DATA;
    assign switch_ok  = !st_q.level && (mode_req != st_q.mode);
    assign enter_data = switch_ok && (mode_req == MODE_DATA);

    fsk_half_timer #(
        .HALF_HI (HALF_HI),
        .HALF_LO (HALF_LO)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .restart_i  (enter_data),
        .data_bit_i (data_bit_i),
        .flip_o     (flip)
    );

    always_comb begin
        st_d.mode = switch_ok ? mode_req : st_q.mode;
        if (st_d.mode == MODE_SYNC)
            st_d.level = sync_s;
        else if (enter_data)
            st_d.level = 1'b0;
        else if (flip)
            st_d.level = !st_q.level;
        else
            st_d.level = st_q.level;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{mode: MODE_DATA, level: 1'b0};
        else     st_q <= st_d;
    end

    assign tape_o = st_q.level;

    fsk_carrier_watch #(
        .HOLD (CD_HOLD_CYCLES)
    ) u_carrier (
        .clk       (clk),
        .rst       (rst),
        .sense_i   (sense_s),
        .present_o (carrier_det_o)
    );

endmodule

// File: rtl/fsk_tape_tone_chk.sv
module fsk_tape_tone_chk
    import fsk_tone_pkg::*;
#(
    parameter int unsigned HALF_HI = 250,
    parameter int unsigned HALF_LO = 333,
    parameter int unsigned CD_HOLD = 2000
) (
    input logic       clk,
    input logic       rst,
    input logic       tape_o,
    input logic       carrier_det_o,
    input tape_mode_e mode_q,
    input logic       sync_s,
    input logic       sense_s
);

    logic        prev_out_q;
    logic        toggled;
    int unsigned run_q;
    logic        seg_ok_q;
    logic        sense_prev_q;
    int unsigned quiet_q;

    assign toggled = (tape_o != prev_out_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_out_q   <= 1'b0;
            run_q        <= 0;
            seg_ok_q     <= 1'b0;
            sense_prev_q <= 1'b0;
            quiet_q      <= CD_HOLD;
        end else begin
            prev_out_q <= tape_o;
            if (toggled)
                run_q <= 1;
            else if (run_q != 32'hFFFF_FFFF)
                run_q <= run_q + 1;
            seg_ok_q     <= (mode_q == MODE_DATA) ? (seg_ok_q | toggled) : 1'b0;
            sense_prev_q <= sense_s;
            if (sense_s != sense_prev_q)
                quiet_q <= 0;
            else if (quiet_q < CD_HOLD)
                quiet_q <= quiet_q + 1;
        end
    end

    // R1 and R2: every data-mode half timed from a toggle has one of the two lengths
    p_half_len_r1: assert property (@(posedge clk) disable iff (rst)
        (toggled && mode_q == MODE_DATA && seg_ok_q) |-> (run_q == HALF_HI || run_q == HALF_LO));

    p_sync_path_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_q) == MODE_SYNC && mode_q == MODE_SYNC) |-> (tape_o == $past(sync_s)));

    p_mode_when_low_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_q != $past(mode_q)) |-> !$past(tape_o));

    p_enter_data_low_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_q) == MODE_SYNC && mode_q == MODE_DATA) |-> !tape_o);

    p_carrier_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (quiet_q >= CD_HOLD) |-> !carrier_det_o);

    p_reset_idle_r8: assert property (@(posedge clk)
        $past(rst) |-> (!tape_o && !carrier_det_o && mode_q == MODE_DATA));

endmodule

bind fsk_tape_tone fsk_tape_tone_chk #(
    .HALF_HI (HALF_HI),
    .HALF_LO (HALF_LO),
    .CD_HOLD (CD_HOLD_CYCLES)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tape_o        (tape_o),
    .carrier_det_o (carrier_det_o),
    .mode_q        (st_q.mode),
    .sync_s        (sync_s),
    .sense_s       (sense_s)
);

// File: tb/fsk_tape_tone_tb_top.sv
module fsk_tape_tone_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 1_000_000;
    localparam int HI_HZ      = 2000;
    localparam int LO_HZ      = 1500;
    localparam int HOLD       = 2000;
    localparam int WATCHDOG   = 150_000;

    function automatic int exp_half(input int clk_hz, input int tone_hz);
        return $rtoi(real'(clk_hz) / (2.0 * real'(tone_hz)) + 0.5);
    endfunction

    localparam int H_HI = exp_half(CLK_HZ, HI_HZ);
    localparam int H_LO = exp_half(CLK_HZ, LO_HZ);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_mode = 1'b0;
    logic data_bit = 1'b0;
    logic sync_clk = 1'b0;
    logic carrier = 1'b0;
    logic tape;
    logic cdet;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    bit  run_chk  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsk_tape_tone #(
        .CLK_HZ         (CLK_HZ),
        .TONE_HI_HZ     (HI_HZ),
        .TONE_LO_HZ     (LO_HZ),
        .SYNC_STAGES    (2),
        .CD_HOLD_CYCLES (HOLD)
    ) dut_i (
        .clk           (clk),
        .rst           (rst),
        .sync_mode_i   (sync_mode),
        .data_bit_i    (data_bit),
        .sync_clk_i    (sync_clk),
        .carrier_i     (carrier),
        .tape_o        (tape),
        .carrier_det_o (cdet)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic nwait(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Half-length monitor for the random data phase (R1, R2, R3)
    logic mon_last_out = 1'b0;
    logic mon_prev_d   = 1'b0;
    int   mon_run      = 0;
    int   mon_exp      = 0;
    bit   mon_armed    = 1'b0;

    always @(negedge clk) begin
        #1;
        if (tape != mon_last_out) begin
            if (mon_armed && run_chk)
                chk(mon_run == mon_exp, (mon_exp == H_HI) ? "R1" : "R2",
                    mon_run, mon_exp, "half length for sampled data bit (R3)");
            mon_exp   = mon_prev_d ? H_HI : H_LO;
            mon_run   = 1;
            mon_armed = run_chk;
        end else begin
            mon_run++;
        end
        mon_prev_d   = data_bit;
        mon_last_out = tape;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [2:0] hist;
        void'($urandom(32'd20240611));

        // R8: reset state
        nwait(5);
        chk(tape == 1'b0, "R8", tape, 0, "tape during reset");
        chk(cdet == 1'b0, "R8", cdet, 0, "carrier during reset");
        rst = 1'b0;
        nwait(1);
        chk(tape == 1'b0, "R8", tape, 0, "tape after reset");
        chk(cdet == 1'b0, "R8", cdet, 0, "carrier after reset");

        // Into sync mode with the sync clock low
        sync_mode = 1'b1;
        nwait(400);
        chk(tape == 1'b0, "R4", tape, 0, "sync mode with low sync clock");

        // R6: switch into data mode, first low half is a full high-tone half
        data_bit  = 1'b1;
        sync_mode = 1'b0;
        nwait(H_HI);
        chk(tape == 1'b0, "R6", tape, 0, "still low one cycle before first rise");
        nwait(1);
        chk(tape == 1'b1, "R6", tape, 1, "first rise after half+1 cycles");

        // R5: request sync while high, it waits for the falling edge
        sync_mode = 1'b1;
        sync_clk  = 1'b1;
        nwait(H_HI - 1);
        chk(tape == 1'b1, "R5", tape, 1, "high half not cut by mode request");
        nwait(1);
        chk(tape == 1'b0, "R5", tape, 0, "falls at full half length");
        nwait(1);
        chk(tape == 1'b1, "R5", tape, 1, "follows sync clock after deferred switch");
        sync_clk = 1'b0;
        nwait(2);
        chk(tape == 1'b1, "R4", tape, 1, "sync change not visible before 3 cycles");
        nwait(1);
        chk(tape == 1'b0, "R4", tape, 0, "sync change visible at 3 cycles");

        // R4: random sync clock, output is input delayed by three cycles
        hist = 3'b000;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            chk(tape == hist[2], "R4", tape, hist[2], "sync latency");
            hist = {hist[1:0], 1'b0};
            if ($urandom_range(3) == 0) sync_clk = ~sync_clk;
            hist[0] = sync_clk;
        end

        // Back to data mode, random data bit (R1, R2, R3 by the monitor)
        sync_clk = 1'b0;
        nwait(5);
        data_bit  = 1'b0;
        sync_mode = 1'b0;
        run_chk   = 1'b1;
        for (int i = 0; i < 60000; i++) begin
            @(negedge clk);
            if ($urandom_range(149) == 0) data_bit = ~data_bit;
        end
        run_chk = 1'b0;

        // R3: directed mid-half change of the data bit
        data_bit = 1'b1;
        while (tape != 1'b0) @(negedge clk);
        while (tape != 1'b1) @(negedge clk);
        nwait(50);
        data_bit = 1'b0;
        nwait(H_HI - 51);
        chk(tape == 1'b1, "R3", tape, 1, "high half keeps sampled length");
        nwait(1);
        chk(tape == 1'b0, "R3", tape, 0, "falls after high-tone half");
        nwait(H_LO - 1);
        chk(tape == 1'b0, "R3", tape, 0, "next half uses new data bit");
        nwait(1);
        chk(tape == 1'b1, "R3", tape, 1, "rises after low-tone half");

        // R7: carrier detect
        carrier = 1'b1;
        nwait(2);
        chk(cdet == 1'b0, "R7", cdet, 0, "carrier flag before 3 cycles");
        nwait(1);
        chk(cdet == 1'b1, "R7", cdet, 1, "carrier flag at 3 cycles");
        for (int k = 0; k < 20; k++) begin
            nwait(40);
            chk(cdet == 1'b1, "R7", cdet, 1, "carrier held by toggles");
            carrier = ~carrier;
        end
        nwait(HOLD + 2);
        chk(cdet == 1'b1, "R7", cdet, 1, "carrier flag before timeout");
        nwait(1);
        chk(cdet == 1'b0, "R7", cdet, 0, "carrier flag drops after timeout");
        nwait(3000);
        chk(cdet == 1'b0, "R7", cdet, 0, "carrier flag stays low when quiet");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule